// File: doc/BRIEF.md
# Frame-Counter Video Timing Generator

This block generates the sync and data-enable timing for a raster display interface and the pixel value that goes with each clock. A single counter runs across the whole frame, one count per pixel clock. The horizontal position is derived from that counter, and all vertical limits are compared directly against it. Vertical sync length and the vertical display window are therefore programmed as absolute pixel-clock offsets into the frame, not as line numbers.

Software programs the block through a simple register write bus with a combinational read port. Every timing, colour, polarity and format register has a shadow copy. The running engine only picks up new values at a frame boundary. The run/stop bit also takes effect only at a frame boundary, so a stop always lets the current frame finish. Outside the display window the output pixel is a border colour. When the pixel source reports starvation, the output is a separate fill colour. In-window pixels have their component depth reduced according to a panel format code. Line and frame counters can be read over the bus and can each be enabled on their own.

Top module: `disp_timing_engine`

## Requirements
- R1: After reset the outputs are all low and the pixel is 0. Register reads return the following: run bit (address 0) is 0, border colour (address 7) is 0, starvation colour (address 8) is 0xFF, polarity (address 9) is 0, counter enable (address 10) is 0, and format (address 11) reads 0x213F.
- R2: Address 1 holds the line period in pixel clocks in bits [11:0] and the hsync width in bits [27:16]. The line position h is the frame count modulo the line period. hsync is active while h is less than the width.
- R3: Address 2 holds the frame period in pixel clocks (bits [23:0]) and address 3 holds the vsync length in pixel clocks. The frame count p runs from 0 to period−1 and then wraps. vsync is active while p is less than the length.
- R4: Data-enable is high exactly when both of these hold: h lies in [start, end] of address 4 (start in bits [11:0], end in bits [27:16]), and p lies in [address 5, address 6], both absolute pixel counts.
- R5: Polarity bit 0 (address 9) drives hsync active-low, and bit 1 drives vsync active-low.
- R6: The pixel output depends on data-enable and starvation. With data-enable low it is the border colour. With data-enable high and the starvation input high it is the starvation colour. Otherwise it is the source pixel after depth reduction.
- R7: Address 11 stores a 6-bit depth code and reads back as 0x2100 OR the code. The codes select 0x00 = 4, 0x15 = 5, 0x2A = 6 and any other code = 8 bits per component. Each 8-bit component (pixel bits [23:16], [15:8], [7:0]) has its low 8 − depth bits cleared.
- R8: Run bit 0 of address 0 behaves as follows. When stopped, a 1 written at clock edge E starts the frame at p = 0 in the cycle after edge E+1. When running, a written 0 takes effect only after the last pixel of the current frame.
- R9: Timing, colour, polarity and format registers written during a frame take effect at p = 0 of the next frame. The frame in progress is unchanged.
- R10: Counter enable (address 10) uses bit 0 for frames and bit 1 for lines. The line counter (address 12) advances on the last pixel of each line. The frame counter (address 13) advances on the last pixel of each frame.
- R11: While stopped, hsync and vsync sit at their inactive level (equal to their polarity bit), data-enable is low, the pixel is the border colour, and both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| srcPixel | input | 24 | Pixel from the source, three 8-bit components |
| srcUnderflow | input | 1 | Source has no pixel this cycle |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data-enable |
| pixelOut | output | 24 | Output pixel |

## Verification
Any fault in the frame counter, line position or the moment of shadow loading shows up on the sync and data-enable outputs in the same clock. For that reason the bench predicts every output value cycle by cycle over whole frames and compares against them. A run bit that changes away from the frame boundary shifts the first pixel of a frame, or cuts the last frame short, and the next compared cycle exposes it. Counter faults are only visible through register reads, so the counters are read after a stop and read again a few idle cycles later.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int REG_AW = 4;
  localparam int FMT_W  = 6;
  localparam logic [31:0] FMT_BASE = 32'h0000_2100;
  localparam logic [FMT_W-1:0] FMT_D4 = 6'h00;
  localparam logic [FMT_W-1:0] FMT_D5 = 6'h15;
  localparam logic [FMT_W-1:0] FMT_D6 = 6'h2A;
  localparam logic [FMT_W-1:0] FMT_D8 = 6'h3F;

  typedef enum logic [REG_AW-1:0] {
    REG_RUN      = 4'd0,
    REG_HSYNC    = 4'd1,
    REG_VPERIOD  = 4'd2,
    REG_VLEN     = 4'd3,
    REG_HWIN     = 4'd4,
    REG_VSTART   = 4'd5,
    REG_VEND     = 4'd6,
    REG_BORDER   = 4'd7,
    REG_UFCOL    = 4'd8,
    REG_POL      = 4'd9,
    REG_CNTEN    = 4'd10,
    REG_FORMAT   = 4'd11,
    REG_LINECNT  = 4'd12,
    REG_FRAMECNT = 4'd13
  } dteReg_e;

  // Strobes from timing control to the pixel datapath
  typedef struct packed {
    logic run;
    logic hsyncOn;
    logic vsyncOn;
    logic deOn;
  } dteStrobe_t;
endpackage

// File: rtl/dte_ctrl.sv
module dte_ctrl
  import dte_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HW     = 12,
  parameter int CW     = 24,
  parameter int PIX_W  = 24,
  parameter int LCNT_W = 16,
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output dteStrobe_t        stbO,
  output logic              actPolH,
  output logic              actPolV,
  output logic [FMT_W-1:0]  actFmt,
  output logic [PIX_W-1:0]  actBorder,
  output logic [PIX_W-1:0]  actUfCol
);
  localparam int HI = 16;
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [LCNT_W-1:0] L_ONE = LCNT_W'(1);
  localparam logic [FCNT_W-1:0] F_ONE = FCNT_W'(1);

  // Programmed (shadow) registers
  logic              runReg;
  logic [HW-1:0]     hPerR, hPulseR, hStartR, hEndR;
  logic [CW-1:0]     vPerR, vLenR, vStartR, vEndR;
  logic [PIX_W-1:0]  borderR, ufColR;
  logic [1:0]        polR, cntEnR;
  logic [FMT_W-1:0]  fmtR;

  // Active set used by the running engine
  logic [HW-1:0]     hPerA, hPulseA, hStartA, hEndA;
  logic [CW-1:0]     vPerA, vLenA, vStartA, vEndA;

  logic              runQ;
  logic [CW-1:0]     pixCnt;
  logic [HW-1:0]     hPos;
  logic [LCNT_W-1:0] lineCnt;
  logic [FCNT_W-1:0] frameCnt;
  logic              lineLast, frameLast, loadCfg;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      hPerR   <= '0;
      hPulseR <= '0;
      hStartR <= '0;
      hEndR   <= '0;
      vPerR   <= '0;
      vLenR   <= '0;
      vStartR <= '0;
      vEndR   <= '0;
      borderR <= '0;
      ufColR  <= PIX_W'(8'hFF);
      polR    <= '0;
      cntEnR  <= '0;
      fmtR    <= FMT_D8;
    end else if (regWe) begin
      case (regAddr)
        REG_RUN:     runReg <= regWdata[0];
        REG_HSYNC:   begin hPerR <= regWdata[HW-1:0]; hPulseR <= regWdata[HI +: HW]; end
        REG_VPERIOD: vPerR <= regWdata[CW-1:0];
        REG_VLEN:    vLenR <= regWdata[CW-1:0];
        REG_HWIN:    begin hStartR <= regWdata[HW-1:0]; hEndR <= regWdata[HI +: HW]; end
        REG_VSTART:  vStartR <= regWdata[CW-1:0];
        REG_VEND:    vEndR <= regWdata[CW-1:0];
        REG_BORDER:  borderR <= regWdata[PIX_W-1:0];
        REG_UFCOL:   ufColR <= regWdata[PIX_W-1:0];
        REG_POL:     polR <= regWdata[1:0];
        REG_CNTEN:   cntEnR <= regWdata[1:0];
        REG_FORMAT:  fmtR <= regWdata[FMT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_RUN:      regRdata[0] = runReg;
      REG_HSYNC:    begin regRdata[HW-1:0] = hPerR; regRdata[HI +: HW] = hPulseR; end
      REG_VPERIOD:  regRdata[CW-1:0] = vPerR;
      REG_VLEN:     regRdata[CW-1:0] = vLenR;
      REG_HWIN:     begin regRdata[HW-1:0] = hStartR; regRdata[HI +: HW] = hEndR; end
      REG_VSTART:   regRdata[CW-1:0] = vStartR;
      REG_VEND:     regRdata[CW-1:0] = vEndR;
      REG_BORDER:   regRdata[PIX_W-1:0] = borderR;
      REG_UFCOL:    regRdata[PIX_W-1:0] = ufColR;
      REG_POL:      regRdata[1:0] = polR;
      REG_CNTEN:    regRdata[1:0] = cntEnR;
      REG_FORMAT:   regRdata = DATA_W'(FMT_BASE) | DATA_W'(fmtR);
      REG_LINECNT:  regRdata[LCNT_W-1:0] = lineCnt;
      REG_FRAMECNT: regRdata[FCNT_W-1:0] = frameCnt;
      default: ;
    endcase
  end

  assign lineLast  = runQ && (hPos == hPerA - H_ONE);
  assign frameLast = runQ && (pixCnt == vPerA - C_ONE);
  // While stopped the active set follows the registers; while running it
  // reloads only at the frame boundary.
  assign loadCfg   = !runQ || frameLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      pixCnt    <= '0;
      hPos      <= '0;
      hPerA     <= '0;
      hPulseA   <= '0;
      hStartA   <= '0;
      hEndA     <= '0;
      vPerA     <= '0;
      vLenA     <= '0;
      vStartA   <= '0;
      vEndA     <= '0;
      actBorder <= '0;
      actUfCol  <= PIX_W'(8'hFF);
      actPolH   <= 1'b0;
      actPolV   <= 1'b0;
      actFmt    <= FMT_D8;
    end else if (loadCfg) begin
      runQ      <= runReg;
      pixCnt    <= '0;
      hPos      <= '0;
      hPerA     <= hPerR;
      hPulseA   <= hPulseR;
      hStartA   <= hStartR;
      hEndA     <= hEndR;
      vPerA     <= vPerR;
      vLenA     <= vLenR;
      vStartA   <= vStartR;
      vEndA     <= vEndR;
      actBorder <= borderR;
      actUfCol  <= ufColR;
      actPolH   <= polR[0];
      actPolV   <= polR[1];
      actFmt    <= fmtR;
    end else begin
      pixCnt <= pixCnt + C_ONE;
      hPos   <= lineLast ? '0 : hPos + H_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt  <= '0;
      frameCnt <= '0;
    end else begin
      if (lineLast && cntEnR[1])  lineCnt  <= lineCnt + L_ONE;
      if (frameLast && cntEnR[0]) frameCnt <= frameCnt + F_ONE;
    end
  end

  assign stbO.run     = runQ;
  assign stbO.hsyncOn = runQ && (hPos < hPulseA);
  assign stbO.vsyncOn = runQ && (pixCnt < vLenA);
  assign stbO.deOn    = runQ && (hPos >= hStartA) && (hPos <= hEndA)
                        && (pixCnt >= vStartA) && (pixCnt <= vEndA);

  // R8
  run_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(frameLast));
  // R8
  run_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (pixCnt == '0) && (hPos == '0));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> $stable(lineCnt) && $stable(frameCnt));
  // R9
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !$past(loadCfg) |-> $stable(hPerA) && $stable(vPerA) && $stable(vStartA));
  // R2
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ && (hPerA != '0) |-> hPos < hPerA);
  // R3
  pix_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ && (vPerA != '0) |-> pixCnt < vPerA);
endmodule

// File: rtl/dte_dpath.sv
module dte_dpath
  import dte_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  parameter int PIX_W  = COMP_W * NCOMP
) (
  input  logic             clk,
  input  logic             rstN,
  input  dteStrobe_t       stbI,
  input  logic             polH,
  input  logic             polV,
  input  logic [FMT_W-1:0] fmt,
  input  logic [PIX_W-1:0] border,
  input  logic [PIX_W-1:0] ufCol,
  input  logic [PIX_W-1:0] srcPix,
  input  logic             srcUnderflow,
  output logic             hsyncO,
  output logic             vsyncO,
  output logic             deO,
  output logic [PIX_W-1:0] pixelO
);
  logic [2:0]        dropBits;
  logic [COMP_W-1:0] compMask;
  logic [PIX_W-1:0]  reduced;

  always_comb begin
    case (fmt)
      FMT_D4:  dropBits = 3'd4;
      FMT_D5:  dropBits = 3'd3;
      FMT_D6:  dropBits = 3'd2;
      default: dropBits = 3'd0;
    endcase
  end

  assign compMask = {COMP_W{1'b1}} << dropBits;

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign reduced[c*COMP_W +: COMP_W] = srcPix[c*COMP_W +: COMP_W] & compMask;
  end

  assign hsyncO = stbI.hsyncOn ^ polH;
  assign vsyncO = stbI.vsyncOn ^ polV;
  assign deO    = stbI.deOn;
  assign pixelO = !stbI.deOn ? border : (srcUnderflow ? ufCol : reduced);

  // R11
  idle_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stbI.run |-> !deO && (hsyncO == polH) && (vsyncO == polV));
  // R4
  de_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    deO |-> stbI.run);
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
  import dte_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HW     = 12,
  parameter int CW     = 24,
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  parameter int LCNT_W = 16,
  parameter int FCNT_W = 16,
  localparam int PIX_W = COMP_W * NCOMP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PIX_W-1:0]  srcPixel,
  input  logic              srcUnderflow,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic [PIX_W-1:0]  pixelOut
);
  dteStrobe_t       stb;
  logic             polH, polV;
  logic [FMT_W-1:0] fmt;
  logic [PIX_W-1:0] border, ufCol;

  dte_ctrl #(
    .DATA_W(DATA_W), .HW(HW), .CW(CW), .PIX_W(PIX_W),
    .LCNT_W(LCNT_W), .FCNT_W(FCNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stbO(stb),
    .actPolH(polH), .actPolV(polV), .actFmt(fmt),
    .actBorder(border), .actUfCol(ufCol)
  );

  dte_dpath #(.COMP_W(COMP_W), .NCOMP(NCOMP), .PIX_W(PIX_W)) uDpath (
    .clk(clk), .rstN(rstN), .stbI(stb), .polH(polH), .polV(polV),
    .fmt(fmt), .border(border), .ufCol(ufCol), .srcPix(srcPixel),
    .srcUnderflow(srcUnderflow), .hsyncO(hsyncOut), .vsyncO(vsyncOut),
    .deO(deOut), .pixelO(pixelOut)
  );
endmodule

// File: tb/sim_disp_timing_engine.sv
module sim_disp_timing_engine;
  import dte_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [3:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [23:0] srcPixel;
  logic        srcUnderflow;
  logic        hsyncOut, vsyncOut, deOut;
  logic [23:0] pixelOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  disp_timing_engine u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcPixel(srcPixel),
    .srcUnderflow(srcUnderflow), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pixelOut(pixelOut)
  );

  typedef struct {
    int hPer, hPulse, hStart, hEnd, vPer, vLen, vStart, vEnd, bpc;
    logic [1:0]  pol;
    logic [23:0] border, ufc;
  } cfg_t;

  typedef struct packed {
    logic [31:0] cyc;
    logic        hs, vs, de;
    logic [23:0] pix;
    logic [7:0]  grp;
  } item_t;

  item_t sbq[$];

  function automatic logic [23:0] depthCut(logic [23:0] p, int bpc);
    logic [7:0] m = 8'hFF << (8 - bpc);
    return {p[23:16] & m, p[15:8] & m, p[7:0] & m};
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: expected outputs of one running frame (R2 R3 R4 R5 R6 R7)
  task automatic pushFrame(int st, cfg_t c, int ufFrom, int ufTo, int grp);
    for (int p = 0; p < c.vPer; p++) begin
      item_t it;
      int h = p % c.hPer;
      logic uf = (st + p >= ufFrom) && (st + p < ufTo);
      it.cyc = st + p;
      it.hs  = (h < c.hPulse) ^ c.pol[0];
      it.vs  = (p < c.vLen) ^ c.pol[1];
      it.de  = (h >= c.hStart) && (h <= c.hEnd) && (p >= c.vStart) && (p <= c.vEnd);
      it.pix = it.de ? (uf ? c.ufc : depthCut(srcPixel, c.bpc)) : c.border;
      it.grp = 8'(grp);
      sbq.push_back(it);
    end
  endtask

  // Driver: expected outputs while stopped (R11)
  task automatic pushIdle(int st, int n, cfg_t c);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.cyc = st + k;
      it.hs  = c.pol[0];
      it.vs  = c.pol[1];
      it.de  = 1'b0;
      it.pix = c.border;
      it.grp = 8'd11;
      sbq.push_back(it);
    end
  endtask

  // Monitor: compare each expected item in its cycle
  always @(negedge clk) begin
    item_t it;
    while (sbq.size() > 0 && int'(sbq[0].cyc) <= cyc) begin
      it = sbq.pop_front();
      checks++;
      if (int'(it.cyc) != cyc) begin
        errors++;
        $display("FAIL R%0d item for cycle %0d seen at %0d (actual cycle %0d expected %0d)",
                 it.grp, it.cyc, cyc, cyc, it.cyc);
      end else if ({hsyncOut, vsyncOut, deOut, pixelOut} !== {it.hs, it.vs, it.de, it.pix}) begin
        errors++;
        $display("FAIL R%0d cyc=%0d actual hs=%b vs=%b de=%b pix=%h expected hs=%b vs=%b de=%b pix=%h",
                 it.grp, cyc, hsyncOut, vsyncOut, deOut, pixelOut, it.hs, it.vs, it.de, it.pix);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic chkReg(logic [3:0] a, logic [31:0] exp, int rq);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdata !== exp) begin
      errors++;
      $display("FAIL R%0d reg %0d actual %h expected %h", rq, a, regRdata, exp);
    end
  endtask

  task automatic waitCyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic waitDrain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finishRun();
  end

  initial begin
    cfg_t cA, cB, cC, cD;
    int c0, c1;
    regWe = 1'b0; regAddr = '0; regWdata = '0;
    srcPixel = 24'hA5C3E7; srcUnderflow = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs after reset
    checks++;
    if ({hsyncOut, vsyncOut, deOut, pixelOut} !== 27'h0) begin
      errors++;
      $display("FAIL R1 outputs actual %b%b%b %h expected 000 000000",
               hsyncOut, vsyncOut, deOut, pixelOut);
    end
    // R1: register reset values
    chkReg(REG_RUN, 32'h0, 1);
    chkReg(REG_BORDER, 32'h0, 1);
    chkReg(REG_UFCOL, 32'hFF, 1);
    chkReg(REG_POL, 32'h0, 1);
    chkReg(REG_CNTEN, 32'h0, 1);
    chkReg(REG_FORMAT, 32'h213F, 1);

    cA = '{hPer:10, hPulse:2, hStart:4, hEnd:8, vPer:60, vLen:10, vStart:20,
           vEnd:49, bpc:8, pol:2'b00, border:24'h0, ufc:24'hFF};
    wr(REG_HSYNC, (32'd2 << 16) | 32'd10);
    wr(REG_VPERIOD, 32'd60);
    wr(REG_VLEN, 32'd10);
    wr(REG_HWIN, (32'd8 << 16) | 32'd4);
    wr(REG_VSTART, 32'd20);
    wr(REG_VEND, 32'd49);
    wr(REG_CNTEN, 32'd3);
    // R8: start latency from stopped, then stop after frame completes
    wr(REG_RUN, 32'd1);
    c0 = cyc + 1;
    pushFrame(c0, cA, 0, 0, 2);
    pushFrame(c0 + 60, cA, 0, 0, 8);
    pushIdle(c0 + 120, 6, cA);
    waitCyc(c0 + 80);
    wr(REG_RUN, 32'd0);
    waitDrain();
    // R10: both counters enabled over two frames
    chkReg(REG_LINECNT, 32'd12, 10);
    chkReg(REG_FRAMECNT, 32'd2, 10);
    repeat (5) @(negedge clk);
    // R11: counters hold while stopped
    chkReg(REG_LINECNT, 32'd12, 11);
    chkReg(REG_FRAMECNT, 32'd2, 11);

    // R9 R5 R6 R7: mid-frame writes apply at the next frame
    cB = cA;
    cB.hPulse = 3; cB.pol = 2'b11; cB.bpc = 6;
    cB.border = 24'h123456; cB.ufc = 24'h00FF00;
    cC = cB; cC.bpc = 5;
    cD = cB; cD.bpc = 4;
    wr(REG_CNTEN, 32'd2);
    wr(REG_RUN, 32'd1);
    c1 = cyc + 1;
    pushFrame(c1, cA, 0, 0, 9);
    pushFrame(c1 + 60, cB, 0, 0, 5);
    pushFrame(c1 + 120, cC, c1 + 120, c1 + 150, 6);
    pushFrame(c1 + 180, cD, 0, 0, 7);
    pushIdle(c1 + 240, 6, cD);
    fork
      begin
        wr(REG_HSYNC, (32'd3 << 16) | 32'd10);
        wr(REG_POL, 32'd3);
        wr(REG_FORMAT, 32'h2A);
        wr(REG_BORDER, 32'h123456);
        wr(REG_UFCOL, 32'h00FF00);
        waitCyc(c1 + 65);
        wr(REG_FORMAT, 32'h15);
        waitCyc(c1 + 125);
        wr(REG_FORMAT, 32'h00);
        waitCyc(c1 + 185);
        wr(REG_RUN, 32'd0);
      end
      begin
        while (cyc < c1 + 120) begin @(posedge clk); #2; end
        srcUnderflow = 1'b1;
        while (cyc < c1 + 150) begin @(posedge clk); #2; end
        srcUnderflow = 1'b0;
      end
    join
    waitDrain();
    // R10: line counter only; frame counter disabled
    chkReg(REG_LINECNT, 32'd36, 10);
    chkReg(REG_FRAMECNT, 32'd2, 10);
    // R7: format readback carries the fixed base
    chkReg(REG_FORMAT, 32'h2100, 7);
    finishRun();
  end
endmodule